// File: doc/BRIEF.md
# PHY power and mode sequencer

This block sequences the power state of an on-chip USB 2.0 PHY and sets how the PHY's VBUS and ID comparator results reach the controller. A power-up command releases the PHY from reset and from both power-down controls and turns its PLL on, all in the same clock edge. The block then reports busy until the PHY raises its clock-good signal, after which it reports ready. If clock-good does not arrive within a programmable number of cycles, the block flags a timeout and falls back to idle with the PHY powered down.

A power-down command is refused while a companion USB 1.1 port still takes its reference clock from this PHY. A refused power-down sets a sticky flag, and the next command clears it. A separate mode command picks one of three cases. Host mode forces VBUS valid with ID low. Device mode forces VBUS valid with ID high. OTG mode lets the real comparator outputs through. Any other code clears the override.

Top module: `phy_pwr_seq`

## Requirements
- R1: A power-up command sets, at the next clock edge, `phy_rst`=0, `phy_pd`=0, `otg_pd`=0 and `pll_on`=1, and clears `refused` and `tmo_err`.
- R2: After a power-up, `busy`=1 and `ready`=0 until an edge samples `clk_good`=1. After that edge `busy`=0 and `ready`=1.
- R3: A power-down is refused when `u11_ext_clk`=0 and `u11_suspend_m`=1. A refused power-down leaves the power outputs and `ready`/`busy` unchanged and sets `refused`=1.
- R4: An accepted power-down sets `phy_pd`=1 and `otg_pd`=1 and returns to idle (`ready`=0, `busy`=0). It leaves `phy_rst` and `pll_on` as they were.
- R5: Mode code 3'd1 (host) sets `mode_q`=2'b10. While this field holds, `vbus_out`=1 and `id_out`=0.
- R6: Mode code 3'd2 (device) sets `mode_q`=2'b11. While this field holds, `vbus_out`=1 and `id_out`=1.
- R7: Mode code 3'd3 (OTG) sets `mode_q`=2'b00. With `mode_q`=2'b00, `vbus_out` follows `vbus_cmp` and `id_out` follows `id_cmp`.
- R8: Mode codes 0 and 4 to 7 clear `mode_q` to 2'b00. A later unsupported code keeps it cleared.
- R9: `refused` stays high until the next command of any kind (power-up, power-down or mode). That command clears it, unless it is itself a refused power-down.
- R10: With limit L (with `tmo_limit`=L ≥ 1), if `clk_good` is low on all of the first L edges after power-up, then the L-th edge sets `tmo_err`=1, `phy_pd`=1 and `otg_pd`=1, and returns to idle. If `clk_good` is high on the L-th edge itself, the block becomes ready and no timeout is flagged.
- R11: After reset: `phy_rst`=1, `phy_pd`=1, `otg_pd`=1, `pll_on`=0, `mode_q`=2'b00, and `ready`, `busy`, `refused` and `tmo_err` are all 0.
- R12: When power-up and power-down arrive in the same cycle, power-up wins. The power-down is ignored and cannot set `refused`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_up | input | 1 | Power-up command pulse |
| cmd_down | input | 1 | Power-down command pulse |
| cmd_mode | input | 1 | Mode-select command pulse |
| mode_code | input | 3 | Requested mode: 1 host, 2 device, 3 OTG, other values unsupported |
| tmo_limit | input | TMO_W | Number of cycles to wait for clock-good |
| clk_good | input | 1 | PHY clock-good indication |
| u11_ext_clk | input | 1 | High when the USB 1.1 port uses its own reference clock |
| u11_suspend_m | input | 1 | USB 1.1 suspend-M (active) indication |
| vbus_cmp | input | 1 | Raw VBUS-valid comparator result |
| id_cmp | input | 1 | Raw ID comparator result |
| phy_rst | output | 1 | PHY reset |
| phy_pd | output | 1 | PHY power-down |
| otg_pd | output | 1 | OTG block power-down |
| pll_on | output | 1 | PHY PLL enable |
| mode_q | output | 2 | Override field: bit 1 forces the comparators, bit 0 is the forced ID |
| vbus_out | output | 1 | VBUS-valid seen by the controller |
| id_out | output | 1 | ID seen by the controller |
| ready | output | 1 | PHY powered and clock good |
| busy | output | 1 | Waiting for clock-good |
| refused | output | 1 | Sticky: last power-down was refused |
| tmo_err | output | 1 | Sticky: clock-good wait timed out |

## Verification
Two events can meet in one cycle: the timeout expiring, and clock-good arriving on that same edge. The bench sweeps every arrival cycle against every limit from 1 to 5, so the arrival lands before, exactly on, and after the expiry edge. The predicted outcome is ready whenever the arrival cycle is no later than the limit, and a timeout otherwise. The bench also pairs a power-up with a power-down, and a power-down with a mode command, in the same cycle, and checks that each part lands as the requirements state.

// File: rtl/phy_pwr_seq.sv
`timescale 1ns/1ps
module phy_pwr_seq #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_up,
  input  logic             cmd_down,
  input  logic             cmd_mode,
  input  logic [2:0]       mode_code,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             clk_good,
  input  logic             u11_ext_clk,
  input  logic             u11_suspend_m,
  input  logic             vbus_cmp,
  input  logic             id_cmp,
  output logic             phy_rst,
  output logic             phy_pd,
  output logic             otg_pd,
  output logic             pll_on,
  output logic [1:0]       mode_q,
  output logic             vbus_out,
  output logic             id_out,
  output logic             ready,
  output logic             busy,
  output logic             refused,
  output logic             tmo_err
);

  typedef enum logic [1:0] {S_OFF, S_WAIT, S_ON} st_t;

  localparam logic [2:0] CODE_HOST = 3'd1;
  localparam logic [2:0] CODE_DEV  = 3'd2;
  localparam logic [1:0] OVR_NONE  = 2'b00;
  localparam logic [1:0] OVR_HOST  = 2'b10;
  localparam logic [1:0] OVR_DEV   = 2'b11;
  localparam logic [TMO_W:0] ONE   = 1;

  st_t              state;
  logic [TMO_W-1:0] cnt;
  logic [TMO_W:0]   cnt_nx;

  wire veto    = !u11_ext_clk && u11_suspend_m;
  wire dn_ok   = cmd_down && !cmd_up && !veto;
  wire dn_bad  = cmd_down && !cmd_up && veto;
  wire any_cmd = cmd_up || cmd_down || cmd_mode;

  assign cnt_nx = {1'b0, cnt} + ONE;
  wire expire = (state == S_WAIT) && !clk_good && (cnt_nx >= {1'b0, tmo_limit});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_OFF;
      phy_rst <= 1'b1;
      phy_pd  <= 1'b1;
      otg_pd  <= 1'b1;
      pll_on  <= 1'b0;
      cnt     <= '0;
    end else if (cmd_up) begin
      state   <= S_WAIT;
      phy_rst <= 1'b0;
      phy_pd  <= 1'b0;
      otg_pd  <= 1'b0;
      pll_on  <= 1'b1;
      cnt     <= '0;
    end else if (dn_ok || expire) begin
      state  <= S_OFF;
      phy_pd <= 1'b1;
      otg_pd <= 1'b1;
    end else if (state == S_WAIT) begin
      if (clk_good) state <= S_ON;
      else          cnt   <= cnt_nx[TMO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refused <= 1'b0;
      tmo_err <= 1'b0;
    end else if (any_cmd) begin
      refused <= dn_bad;
      tmo_err <= expire && !cmd_up && !cmd_down;
    end else if (expire) begin
      tmo_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= OVR_NONE;
    else if (cmd_mode) begin
      case (mode_code)
        CODE_HOST: mode_q <= OVR_HOST;
        CODE_DEV:  mode_q <= OVR_DEV;
        default:   mode_q <= OVR_NONE;
      endcase
    end
  end

  assign vbus_out = mode_q[1] ? 1'b1 : vbus_cmp;
  assign id_out   = mode_q[1] ? mode_q[0] : id_cmp;
  assign ready    = (state == S_ON);
  assign busy     = (state == S_WAIT);

  // R1
  a_r1_up_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_up |=> (!phy_rst && !phy_pd && !otg_pd && pll_on));
  // R2
  a_r2_ready_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(clk_good));
  // R3
  a_r3_refuse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_down && !cmd_up && veto) |=> (refused && $stable(phy_pd) && $stable(otg_pd)));
  // R4
  a_r4_down_powers_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_down && !cmd_up && !veto) |=> (phy_pd && otg_pd && !ready && !busy));
  // R5
  a_r5_host_force: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mode && mode_code == 3'd1) |=> (vbus_out && !id_out));
  // R6
  a_r6_dev_force: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mode && mode_code == 3'd2) |=> (vbus_out && id_out));
  // R10
  a_r10_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err) |-> ($past(busy) && !busy && phy_pd));
  // R12
  a_r12_up_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_up && cmd_down) |=> (busy && !refused));

endmodule

// File: tb/sim_phy_pwr_seq.sv
`timescale 1ns/1ps
module sim_phy_pwr_seq;
  logic clk = 0, rst_n = 0;
  logic cmd_up = 0, cmd_down = 0, cmd_mode = 0;
  logic [2:0] mode_code = 0;
  logic [15:0] tmo_limit = 16'd4;
  logic clk_good = 0, u11_ext_clk = 1, u11_suspend_m = 0, vbus_cmp = 0, id_cmp = 0;
  logic phy_rst, phy_pd, otg_pd, pll_on, vbus_out, id_out, ready, busy, refused, tmo_err;
  logic [1:0] mode_q;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  phy_pwr_seq u0 (.*);

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pwr_down_clean();
    u11_ext_clk = 1; cmd_down = 1; step(); cmd_down = 0;
  endtask

  task automatic pwr_up();
    cmd_up = 1; step(); cmd_up = 0;
  endtask

  initial begin
    step(); step(); rst_n = 1; step();
    // R11 reset state
    chk("R11 phy_rst", phy_rst, 1); chk("R11 phy_pd", phy_pd, 1);
    chk("R11 otg_pd", otg_pd, 1);   chk("R11 pll_on", pll_on, 0);
    chk("R11 mode_q", mode_q, 0);
    chk("R11 flags", {ready, busy, refused, tmo_err}, 0);

    // R1/R2/R10: sweep limit against clock-good arrival cycle
    for (int L = 1; L <= 5; L++) begin
      for (int d = 1; d <= 7; d++) begin
        int m;
        m = (d < L) ? d : L;
        tmo_limit = 16'(L);
        clk_good = 0;
        pwr_up();
        chk("R1 up outputs", {phy_rst, phy_pd, otg_pd, pll_on}, 4'b0001);
        chk("R1 flags cleared", {refused, tmo_err}, 0);
        for (int k = 1; k <= m; k++) begin
          chk("R2 busy while waiting", {busy, ready}, 2'b10);
          clk_good = (k >= d);
          step();
        end
        clk_good = 0;
        if (d <= L) begin
          chk("R2 ready after good", {busy, ready, tmo_err}, 3'b010);
          chk("R10 good on expiry edge wins", tmo_err, 0);
        end else begin
          chk("R10 timeout flag", {busy, ready, tmo_err}, 3'b001);
          chk("R10 powered down", {phy_pd, otg_pd}, 2'b11);
        end
        pwr_down_clean();
      end
    end

    // R3/R4/R9: power-down veto sweep from ready
    for (int c = 0; c < 4; c++) begin
      int vetoed;
      tmo_limit = 16'd8;
      pwr_up(); clk_good = 1; step(); clk_good = 0;
      u11_ext_clk = c[0]; u11_suspend_m = c[1];
      vetoed = (!c[0] && c[1]) ? 1 : 0;
      cmd_down = 1; step(); cmd_down = 0;
      if (vetoed) begin
        chk("R3 refused set", refused, 1);
        chk("R3 power kept", {phy_pd, otg_pd, ready}, 3'b001);
        step(); step();
        chk("R9 refused sticky", refused, 1);
        cmd_mode = 1; mode_code = 3'd3; step(); cmd_mode = 0;
        chk("R9 cleared by next command", refused, 0);
      end else begin
        chk("R4 accepted down", {phy_pd, otg_pd, ready, busy, refused}, 5'b11000);
        chk("R4 rst and pll kept", {phy_rst, pll_on}, 2'b01);
      end
      u11_suspend_m = 0;
      pwr_down_clean();
    end

    // R5..R8: every mode code against every comparator pattern
    for (int code = 0; code < 8; code++) begin
      int em;
      em = (code == 1) ? 2 : (code == 2) ? 3 : 0;
      cmd_mode = 1; mode_code = 3'(code); step(); cmd_mode = 0;
      chk(code == 1 ? "R5 field" : code == 2 ? "R6 field" :
          code == 3 ? "R7 field" : "R8 field", mode_q, em);
      for (int p = 0; p < 4; p++) begin
        int ev, ei;
        vbus_cmp = p[0]; id_cmp = p[1];
        #1;
        ev = (em >= 2) ? 1 : p[0];
        ei = (em >= 2) ? em - 2 : p[1];
        chk(code == 1 ? "R5 outputs" : code == 2 ? "R6 outputs" :
            code == 3 ? "R7 outputs" : "R8 outputs", {vbus_out, id_out}, {ev[0], ei[0]});
      end
    end
    // R8: unsupported after host, then again
    cmd_mode = 1; mode_code = 3'd1; step();
    mode_code = 3'd6; step();
    chk("R8 cleared after host", mode_q, 0);
    mode_code = 3'd7; step(); cmd_mode = 0;
    chk("R8 stays cleared", mode_q, 0);

    // R12: up and down together, with veto active
    u11_ext_clk = 0; u11_suspend_m = 1;
    cmd_up = 1; cmd_down = 1; step(); cmd_up = 0; cmd_down = 0;
    chk("R12 up wins", {busy, phy_pd, refused}, 3'b100);
    u11_suspend_m = 0;
    // down and mode together
    u11_ext_clk = 1; cmd_down = 1; cmd_mode = 1; mode_code = 3'd2; step();
    cmd_down = 0; cmd_mode = 0;
    chk("R4 down with mode", {phy_pd, busy}, 2'b10);
    chk("R6 mode with down", mode_q, 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule